// File: doc/BRIEF.md
# Byte-Parity Memory Status Register

This block is the single status and control register of a byte-parity memory board on a 16-bit word bus. On the write path it computes one parity bit for each byte of the word being stored, and can deliberately invert those bits for diagnostics. On the read path it compares the data with the stored parity bits. When a byte does not match, it raises an error flag and records the upper address bits of the failing access. If software has enabled reporting, it also drives the parity-error signal lines on the bus.

Software reaches the register at one of eight consecutive even word addresses in the I/O page, chosen by a strap. A separate strap can remove the register from the bus altogether. One error-address field shows either the low or the high part of the recorded address, depending on a view-select bit. That field keeps its contents through bus init. Power-up reset (`rst_n`) clears the whole register. Bus init (`bus_init`) clears every bit except that field.

Top module: `pmem_csr`

## Requirements
- R1: After `rst_n` is held low for a clock edge, a read of the selected register address returns 0x0000.
- R2: The register responds, with `reg_ack` high, only when `strap_csr_en` is 1 and `reg_addr` equals octal 17772100 + 2*`strap_csr_sel`. Otherwise `reg_ack` is 0, `reg_rdata` is 0 and writes change nothing. `reg_rdata` is also 0 whenever `reg_rd` is low.
- R3: Bit 15 (error flag), bit 14 (view select), bits 11:5 (address field), bit 2 (wrong-parity mode) and bit 0 (report enable) read back what was written. All other bits read 0, so the readable mask is 0xCFE5.
- R4: A cycle with `bus_init` high clears bits 15, 14, 2 and 0, leaves the recorded address unchanged and ignores a register write in the same cycle.
- R5: `mem_wpar[i]` is the XOR of the eight bits of byte i of `mem_wdata` (even parity). Both bits are inverted only when bit 2 is 1 and `strap_wwp_en` is 1.
- R6: A read (`mem_rd_valid` high) with any byte whose XOR differs from its `mem_rpar` bit sets bit 15 and records `mem_addr[21:11]`, whatever the value of bit 0. A later error overwrites the recorded address.
- R7: With bit 14 = 0, bits 11:5 show address bits 17:11. With bit 14 = 1, bits 11:9 show address bits 17:15 and bits 8:5 show address bits 21:18. A software write to bits 11:5 stores into the positions shown by the value bit 14 had before that write.
- R8: `par_err_d16` is high in the same cycle as a mismatching read only when bit 0 is 1. `par_err_d17` is high only when, in addition, `strap_rpt_both` is 1.
- R9: When `strap_pee_clr_ok` is 0, a register write cannot clear bit 0 once it is set, though it can still set it. When the strap is 1, bit 0 follows the written value.
- R10: When a parity error and a register write land in the same cycle, the error wins for bit 15 and the recorded address. The write still updates bits 14, 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset, clears everything |
| bus_init | input | 1 | Bus init, clears all but the recorded address |
| reg_addr | input | 22 | Register access byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, 0 when not selected |
| reg_ack | output | 1 | Register selected by this access |
| mem_wdata | input | 16 | Word being written to memory |
| mem_wpar | output | 2 | Parity bits to store, one per byte |
| mem_rd_valid | input | 1 | Memory read data valid this cycle |
| mem_rdata | input | 16 | Word read from memory |
| mem_rpar | input | 2 | Stored parity bits read with it |
| mem_addr | input | 22 | Address of the memory read |
| par_err_d16 | output | 1 | Parity error report on data line 16 |
| par_err_d17 | output | 1 | Parity error report on data line 17 |
| strap_csr_en | input | 1 | Register present on the bus |
| strap_csr_sel | input | 3 | Register word address select |
| strap_rpt_both | input | 1 | Report on lines 16 and 17 rather than 16 alone |
| strap_wwp_en | input | 1 | Allow wrong-parity writes |
| strap_pee_clr_ok | input | 1 | Allow software to clear bit 0 |

## Verification
The bench goes after the field remapping. A design that wrote bits 11:5 according to the new view bit, rather than the old one, would record the wrong address bits, and that shows up when the field is read back in the other view. It also puts a parity error and a register write in the same cycle. A design that gave the write priority would lose the flag or the recorded address. Other cases it covers: bus init with a pending write, which would wipe the recorded address or take the write; the clear-lock strap, which would let bit 0 drop; and errors with reporting off, which would either fail to set the flag or drive the report lines.

// File: rtl/pmem_pkg.sv
// Package: shared constants and address-field mapping helpers for the
// byte-parity memory status register. Assumes a 22-bit bus address and a
// 16-bit data word split into 8-bit bytes.
package pmem_pkg;
    localparam int ADDR_W  = 22;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int CAP_LO  = 11;
    localparam int CAP_W   = ADDR_W - CAP_LO;
    localparam int FIELD_W = 7;

    localparam int B_FLAG = 15;
    localparam int B_XEA  = 14;
    localparam int B_FHI  = 11;
    localparam int B_FLO  = 5;
    localparam int B_WWP  = 2;
    localparam int B_PEE  = 0;

    localparam logic [ADDR_W-1:0] CSR_BASE = 22'o17772100;

    // Field contents shown for a recorded address and view select
    function automatic logic [FIELD_W-1:0] field_view(
        input logic [CAP_W-1:0] cap, input logic xea);
        if (xea) return {cap[6:4], cap[10:7]};
        return cap[6:0];
    endfunction

    // Recorded address after software writes the field in a given view
    function automatic logic [CAP_W-1:0] field_store(
        input logic [CAP_W-1:0] cap, input logic xea,
        input logic [FIELD_W-1:0] fld);
        logic [CAP_W-1:0] n;
        n = cap;
        if (xea) begin
            n[6:4]  = fld[6:4];
            n[10:7] = fld[3:0];
        end else begin
            n[6:0] = fld;
        end
        return n;
    endfunction
endpackage

// File: rtl/pmem_wpar_gen.sv
// Module: write-path parity generator. Produces one even-parity bit per
// byte, optionally inverted for diagnostic wrong-parity writes.
// Assumes DATA_W is a whole number of BYTE_W bytes.
module pmem_wpar_gen #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic              invert,
    output logic [NB-1:0]     wpar
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Parity of one byte, flipped in wrong-parity mode
        assign wpar[b] = (^wdata[b*BYTE_W +: BYTE_W]) ^ invert;
    end
endmodule

// File: rtl/pmem_rpar_chk.sv
// Module: read-path parity checker. Flags each byte whose data XOR differs
// from its stored parity bit and raises one error when a valid read has
// any mismatching byte. Purely combinational.
module pmem_rpar_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NB = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [NB-1:0]     rpar,
    input  logic              rd_valid,
    output logic              err
);
    logic [NB-1:0] mism;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Per-byte comparison against the stored bit
        assign mism[b] = (^rdata[b*BYTE_W +: BYTE_W]) != rpar[b];
    end

    // Any mismatching byte on a valid read is an error
    assign err = rd_valid && (|mism);
endmodule

// File: rtl/pmem_csr_regs.sv
// Module: storage for the status register bits and the recorded failing
// address. Power-up reset clears all; bus init clears all but the address.
// A parity error overrides a same-cycle software write for the flag and
// the recorded address.
module pmem_csr_regs
    import pmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_init,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_evt,
    input  logic [CAP_W-1:0]  err_cap,
    input  logic              clr_ok,
    output logic              flag,
    output logic              xea,
    output logic              wwp,
    output logic              pee,
    output logic [CAP_W-1:0]  cap
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[13:12], wdata[4:3], wdata[1]};

    // Control bits: reset, init, software write, error set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            xea  <= 1'b0;
            wwp  <= 1'b0;
            pee  <= 1'b0;
        end else begin
            if (bus_init) begin
                flag <= 1'b0;
                xea  <= 1'b0;
                wwp  <= 1'b0;
                pee  <= 1'b0;
            end else if (csr_we) begin
                flag <= wdata[B_FLAG];
                xea  <= wdata[B_XEA];
                wwp  <= wdata[B_WWP];
                if (wdata[B_PEE] || clr_ok) pee <= wdata[B_PEE];
            end
            if (err_evt) flag <= 1'b1;
        end
    end

    // Recorded address: survives bus init, written by software or error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (err_evt) begin
            cap <= err_cap;
        end else if (csr_we && !bus_init) begin
            cap <= field_store(cap, xea, wdata[B_FHI:B_FLO]);
        end
    end

    a_r6_flag_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> flag);
    a_r6_capture_address: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> cap == $past(err_cap));
    a_r4_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_init && !err_evt) |=> (!flag && !xea && !wwp && !pee));
    a_r4_init_keeps_address: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_init && !err_evt) |=> $stable(cap));
    a_r9_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (pee && !clr_ok && !bus_init) |=> pee);
endmodule

// File: rtl/pmem_csr.sv
// Module: top of the byte-parity memory status register. Decodes the
// strap-selected register address, muxes read data, generates write
// parity, checks read parity and drives the bus error report lines.
// Assumes single-cycle register strobes and combinational read response.
module pmem_csr
    import pmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_init,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 reg_ack,
    input  logic [DATA_W-1:0]    mem_wdata,
    output logic [NBYTES-1:0]    mem_wpar,
    input  logic                 mem_rd_valid,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [NBYTES-1:0]    mem_rpar,
    input  logic [ADDR_W-1:0]    mem_addr,
    output logic                 par_err_d16,
    output logic                 par_err_d17,
    input  logic                 strap_csr_en,
    input  logic [2:0]           strap_csr_sel,
    input  logic                 strap_rpt_both,
    input  logic                 strap_wwp_en,
    input  logic                 strap_pee_clr_ok
);
    logic [ADDR_W-1:0] my_addr;
    logic              hit;
    logic              err_evt;
    logic              flag, xea, wwp, pee;
    logic [CAP_W-1:0]  cap;
    logic              unused_maddr;

    assign unused_maddr = ^mem_addr[CAP_LO-1:0];

    // Register address selected by the straps
    assign my_addr = CSR_BASE + {{(ADDR_W-4){1'b0}}, strap_csr_sel, 1'b0};
    assign hit     = strap_csr_en && (reg_addr == my_addr);
    assign reg_ack = hit && (reg_rd || reg_wr);

    // Read data assembly; unused bits read zero
    always_comb begin
        reg_rdata = '0;
        if (hit && reg_rd) begin
            reg_rdata[B_FLAG]        = flag;
            reg_rdata[B_XEA]         = xea;
            reg_rdata[B_FHI:B_FLO]   = field_view(cap, xea);
            reg_rdata[B_WWP]         = wwp;
            reg_rdata[B_PEE]         = pee;
        end
    end

    pmem_wpar_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wgen (
        .wdata (mem_wdata),
        .invert(wwp && strap_wwp_en),
        .wpar  (mem_wpar)
    );

    pmem_rpar_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rchk (
        .rdata   (mem_rdata),
        .rpar    (mem_rpar),
        .rd_valid(mem_rd_valid),
        .err     (err_evt)
    );

    pmem_csr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_init(bus_init),
        .csr_we  (hit && reg_wr),
        .wdata   (reg_wdata),
        .err_evt (err_evt),
        .err_cap (mem_addr[ADDR_W-1:CAP_LO]),
        .clr_ok  (strap_pee_clr_ok),
        .flag    (flag),
        .xea     (xea),
        .wwp     (wwp),
        .pee     (pee),
        .cap     (cap)
    );

    // Bus report lines follow the error in the same cycle
    assign par_err_d16 = err_evt && pee;
    assign par_err_d17 = err_evt && pee && strap_rpt_both;

    a_r2_silent_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_csr_en |-> (!reg_ack && reg_rdata == '0));
    a_r8_d17_needs_d16: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_d17 |-> par_err_d16);
    a_r8_no_report_unless_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !pee |-> (!par_err_d16 && !par_err_d17));
endmodule

// File: tb/pmem_csr_test.sv
// Bench: seeded random register and memory traffic mixed with directed
// corner cases, checked against a bench-side model of the register.
module pmem_csr_test;
    logic        clk = 1'b0;
    logic        rst_n, bus_init;
    logic [21:0] reg_addr;
    logic        reg_wr, reg_rd;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_ack;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  mem_wpar, mem_rpar;
    logic        mem_rd_valid;
    logic [21:0] mem_addr;
    logic        par_err_d16, par_err_d17;
    logic        strap_csr_en, strap_rpt_both, strap_wwp_en, strap_pee_clr_ok;
    logic [2:0]  strap_csr_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model state
    logic m_flag, m_xea, m_wwp, m_pee;
    logic [10:0] m_cap;

    always #2 clk = ~clk;

    pmem_csr uut (.*);

    function automatic logic [21:0] csr_addr();
        return 22'o17772100 + {16'd0, strap_csr_sel, 1'b0};
    endfunction

    function automatic logic [6:0] m_view();
        if (m_xea) return {m_cap[6:4], m_cap[10:7]};
        return m_cap[6:0];
    endfunction

    function automatic logic [15:0] m_read();
        logic [15:0] v;
        v = 16'h0;
        v[15] = m_flag; v[14] = m_xea; v[11:5] = m_view();
        v[2] = m_wwp; v[0] = m_pee;
        return v;
    endfunction

    function automatic logic m_mism(input logic [15:0] d, input logic [1:0] p);
        return ((^d[7:0]) != p[0]) || ((^d[15:8]) != p[1]);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; mem_rd_valid = 0; bus_init = 0;
    endtask

    task automatic model_write(input logic [15:0] d);
        logic old_xea;
        old_xea = m_xea;
        m_flag = d[15]; m_xea = d[14]; m_wwp = d[2];
        if (d[0] || strap_pee_clr_ok) m_pee = d[0];
        if (old_xea) begin
            m_cap[6:4] = d[11:9]; m_cap[10:7] = d[8:5];
        end else m_cap[6:0] = d[11:5];
    endtask

    task automatic csr_wr(input logic [21:0] a, input logic [15:0] d, input string req);
        logic h;
        h = strap_csr_en && (a == csr_addr());
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        #1 chk({31'd0, reg_ack}, {31'd0, h}, req);
        @(posedge clk);
        if (h) model_write(d);
        #1 idle();
    endtask

    task automatic csr_rd(input logic [21:0] a, input string req);
        logic h;
        h = strap_csr_en && (a == csr_addr());
        reg_addr = a; reg_rd = 1;
        #1 chk({16'd0, reg_rdata}, {16'd0, h ? m_read() : 16'h0}, req);
        chk({31'd0, reg_ack}, {31'd0, h}, req);
        @(posedge clk);
        #1 idle();
    endtask

    task automatic mem_wr_chk(input logic [15:0] d);
        logic inv;
        inv = m_wwp && strap_wwp_en;
        mem_wdata = d;
        #1 chk({30'd0, mem_wpar}, {30'd0, (^d[15:8]) ^ inv, (^d[7:0]) ^ inv}, "R5");
        @(posedge clk);
        #1 idle();
    endtask

    task automatic mem_rd(input logic [15:0] d, input logic [1:0] p, input logic [21:0] a,
                          input logic with_wr, input logic [15:0] wd);
        logic e;
        logic h;
        e = m_mism(d, p);
        h = with_wr && strap_csr_en;
        mem_rdata = d; mem_rpar = p; mem_addr = a; mem_rd_valid = 1;
        if (with_wr) begin
            reg_addr = csr_addr(); reg_wdata = wd; reg_wr = 1;
        end
        #1 chk({30'd0, par_err_d17, par_err_d16},
               {30'd0, e && m_pee && strap_rpt_both, e && m_pee}, "R8");
        @(posedge clk);
        if (h) model_write(wd);
        if (e) begin m_flag = 1; m_cap = a[21:11]; end
        #1 idle();
    endtask

    task automatic do_init(input logic with_wr, input logic [15:0] wd);
        bus_init = 1;
        if (with_wr) begin
            reg_addr = csr_addr(); reg_wdata = wd; reg_wr = 1;
        end
        @(posedge clk);
        m_flag = 0; m_xea = 0; m_wwp = 0; m_pee = 0;
        #1 idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24601));
        idle();
        rst_n = 0; reg_addr = 0; reg_wdata = 0; mem_wdata = 0; mem_rdata = 0;
        mem_rpar = 0; mem_addr = 0;
        strap_csr_en = 1; strap_csr_sel = 3'd3; strap_rpt_both = 0;
        strap_wwp_en = 1; strap_pee_clr_ok = 1;
        m_flag = 0; m_xea = 0; m_wwp = 0; m_pee = 0; m_cap = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        csr_rd(csr_addr(), "R1");
        // R3: mask of writable bits
        csr_wr(csr_addr(), 16'hFFFF, "R3");
        csr_rd(csr_addr(), "R3");
        csr_wr(csr_addr(), 16'h0000, "R3");
        csr_rd(csr_addr(), "R3");
        // R7: field write in low view, read in high view
        csr_wr(csr_addr(), 16'h0AA0, "R7");
        csr_wr(csr_addr(), 16'h4000, "R7");
        csr_rd(csr_addr(), "R7");
        // R2: neighbouring address and disabled register ignored
        csr_wr(csr_addr() + 22'd2, 16'h8005, "R2");
        csr_rd(csr_addr() + 22'd2, "R2");
        strap_csr_en = 0;
        csr_wr(csr_addr(), 16'h8005, "R2");
        strap_csr_en = 1;
        csr_rd(csr_addr(), "R2");
        // R6: error with reporting off still flags and records
        mem_rd(16'h00FF, 2'b01, 22'o12345670, 0, 16'h0);
        csr_rd(csr_addr(), "R6");
        // R5: wrong-parity mode
        csr_wr(csr_addr(), 16'h0004, "R5");
        mem_wr_chk(16'h1301);
        strap_wwp_en = 0;
        mem_wr_chk(16'h1301);
        strap_wwp_en = 1;
        // R9: clear lock
        strap_pee_clr_ok = 0;
        csr_wr(csr_addr(), 16'h0001, "R9");
        csr_wr(csr_addr(), 16'h0000, "R9");
        csr_rd(csr_addr(), "R9");
        strap_pee_clr_ok = 1;
        // R8: report lines, both widths
        strap_rpt_both = 1;
        mem_rd(16'h0100, 2'b00, 22'o07654321, 0, 16'h0);
        strap_rpt_both = 0;
        mem_rd(16'h0100, 2'b00, 22'o07654321, 0, 16'h0);
        // R10: error versus write in the same cycle
        mem_rd(16'h0001, 2'b00, 22'o16000000, 1, 16'h4FE5);
        csr_rd(csr_addr(), "R10");
        // R4: init with a write pending
        do_init(1, 16'hC005);
        csr_rd(csr_addr(), "R4");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: csr_wr(($urandom_range(0, 3) == 0) ? csr_addr() + 22'd4 : csr_addr(),
                             16'($urandom), "R3");
                2, 3: csr_rd(csr_addr(), "R7");
                4:    mem_wr_chk(16'($urandom));
                5, 6: mem_rd(16'($urandom), 2'($urandom), 22'($urandom), 0, 16'h0);
                7:    mem_rd(16'($urandom), 2'($urandom), 22'($urandom), 1, 16'($urandom));
                8:    do_init($urandom_range(0, 1) == 1, 16'($urandom));
                default: begin
                    strap_csr_sel = 3'($urandom);
                    strap_rpt_both = 1'($urandom);
                    strap_wwp_en = 1'($urandom);
                    strap_pee_clr_ok = 1'($urandom);
                    csr_rd(csr_addr(), "R2");
                end
            endcase
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule